// File: doc/BRIEF.md
# Two-Entry Receive Frame Store

This block sits between a bus-side receive engine and a processor. The engine hands over complete frames, each made of four words: frame info, identifier and two data words. The block keeps up to two of them. The processor always sees the oldest stored frame on the read-side outputs, and it frees that frame by pulsing a release input.

A receive interrupt follows the presence of a stored frame. After every release that frees a frame, the interrupt is held low for a fixed gap, even when a second frame is already visible. A frame that arrives when no entry is free is dropped. The drop sets a sticky overrun status. A single-cycle overrun interrupt marks the moment that status goes from 0 to 1. Software returns the status to 0 with a clear command.

The reset input is asynchronous and active low. It is released into the block through a two-stage synchronizer, so the block accepts input two rising edges after `rst_n` goes high.

Top module: `rx_dual_store`

## Requirements
- R1: While reset is asserted, and after it is released, `full_o`, `ovr_o`, `rx_irq_o` and `ovr_irq_o` are 0 and the store is empty.
- R2: A push into a store that has a free entry makes `full_o` 1 after the next rising edge. When the store was empty, the pushed frame then appears on all four read-side outputs.
- R3: The read side always shows the oldest stored frame. A release with two frames stored shows the second frame after that same edge, and `full_o` stays 1.
- R4: A release of the only stored frame makes `full_o` and `rx_irq_o` 0 after that edge.
- R5: After a release that frees a frame, `rx_irq_o` stays 0 for the next 2 cycles. It returns to 1 in the third cycle when a frame is still stored.
- R6: A push while two frames are stored and no release is given is dropped and sets `ovr_o`. The stored frames and their order are left unchanged.
- R7: `ovr_o` stays 1 until `clr_ovr_i` is pulsed. `ovr_irq_o` is a one-cycle pulse that coincides with a 0-to-1 change of `ovr_o`. Drops while `ovr_o` is already 1 give no pulse.
- R8: A release and a push in the same cycle with two frames stored free the oldest frame and accept the new frame, with no overrun.
- R9: A release while the store is empty has no effect: it does not start the interrupt gap of R5.
- R10: A drop in the same cycle as `clr_ovr_i` leaves `ovr_o` at 1 and gives no `ovr_irq_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | A complete frame is offered this cycle |
| push_info_i | input | 32 | Frame-info word of the offered frame |
| push_id_i | input | 32 | Identifier of the offered frame |
| push_da_i | input | 32 | First data word of the offered frame |
| push_db_i | input | 32 | Second data word of the offered frame |
| release_i | input | 1 | Release the visible frame |
| clr_ovr_i | input | 1 | Clear the overrun status |
| rd_info_o | output | 32 | Frame-info word of the oldest stored frame |
| rd_id_o | output | 32 | Identifier of the oldest stored frame |
| rd_da_o | output | 32 | First data word of the oldest stored frame |
| rd_db_o | output | 32 | Second data word of the oldest stored frame |
| full_o | output | 1 | At least one frame is stored |
| ovr_o | output | 1 | Sticky overrun status |
| rx_irq_o | output | 1 | Receive interrupt |
| ovr_irq_o | output | 1 | One-cycle overrun interrupt |

## Verification
The assertions assume that `release_i`, `push_i` and `clr_ovr_i` are single-cycle, synchronous strobes. They also assume that the interrupt gap keeps its default length of two cycles, because the gap checks look back exactly two edges. The stimulus changes every input only on the falling clock edge. It leaves enough idle cycles after reset for the synchronizer to let go before the first push. Releases with an empty store, and drops together with a clear, are driven on purpose, because the block must handle both.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int RXS_WORD_W = 32;

  typedef struct packed {
    logic [RXS_WORD_W-1:0] info;
    logic [RXS_WORD_W-1:0] id;
    logic [RXS_WORD_W-1:0] da;
    logic [RXS_WORD_W-1:0] db;
  } rxs_frame_t;
endpackage

// File: rtl/rxs_rst_sync.sv
module rxs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rxs_store.sv
module rxs_store
  import rxs_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_i,
  input  logic       rel_i,
  input  rxs_frame_t frame_i,
  output rxs_frame_t frame_o,
  output logic       nonempty_o,
  output logic       avail_d_o,
  output logic       rel_eff_o,
  output logic       drop_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  rxs_frame_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rel_eff, push_ok;

  // next state: a release frees its entry before the push asks for room
  always_comb begin
    rel_eff  = rel_i && (cnt_q != '0);
    push_ok  = push_i && (rel_eff || (cnt_q != FULL_CNT));
    cnt_d    = cnt_q + CNT_W'(push_ok) - CNT_W'(rel_eff);
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push_ok) wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
    if (rel_eff) rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic wr_en;
    assign wr_en = push_ok && (wr_ptr_q == PTR_W'(e));
    always_ff @(posedge clk) begin
      if (wr_en) mem[e] <= frame_i;
    end
  end

  assign frame_o    = mem[rd_ptr_q];
  assign nonempty_o = (cnt_q != '0);
  assign avail_d_o  = (cnt_d != '0);
  assign rel_eff_o  = rel_eff;
  assign drop_o     = push_i && !push_ok;
endmodule

// File: rtl/rxs_irq.sv
module rxs_irq #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rel_eff_i,
  input  logic avail_d_i,
  output logic irq_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0] hold_q, hold_d;
  logic          irq_q, irq_d;

  always_comb begin
    if (rel_eff_i)          hold_d = HW'(HOLD_CYC);
    else if (hold_q != '0)  hold_d = hold_q - 1'b1;
    else                    hold_d = hold_q;
    irq_d = avail_d_i && (hold_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      irq_q  <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/rxs_ovr.sv
module rxs_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic drop_i,
  input  logic clr_i,
  output logic ovr_o,
  output logic ovr_irq_o
);
  logic ovr_q, ovr_d;
  logic pulse_q, pulse_d;

  // a drop outranks a clear arriving in the same cycle
  always_comb begin
    ovr_d   = drop_i || (ovr_q && !clr_i);
    pulse_d = ovr_d && !ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      ovr_q   <= ovr_d;
      pulse_q <= pulse_d;
    end
  end

  assign ovr_o     = ovr_q;
  assign ovr_irq_o = pulse_q;
endmodule

// File: rtl/rx_dual_store.sv
module rx_dual_store
  import rxs_pkg::*;
#(
  parameter int DEPTH    = 2,
  parameter int HOLD_CYC = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_i,
  input  logic [RXS_WORD_W-1:0] push_info_i,
  input  logic [RXS_WORD_W-1:0] push_id_i,
  input  logic [RXS_WORD_W-1:0] push_da_i,
  input  logic [RXS_WORD_W-1:0] push_db_i,
  input  logic                  release_i,
  input  logic                  clr_ovr_i,
  output logic [RXS_WORD_W-1:0] rd_info_o,
  output logic [RXS_WORD_W-1:0] rd_id_o,
  output logic [RXS_WORD_W-1:0] rd_da_o,
  output logic [RXS_WORD_W-1:0] rd_db_o,
  output logic                  full_o,
  output logic                  ovr_o,
  output logic                  rx_irq_o,
  output logic                  ovr_irq_o
);
  logic       rst_sync_n;
  rxs_frame_t frame_in, frame_out;
  logic       avail_d, rel_eff, drop;

  assign frame_in = '{info: push_info_i, id: push_id_i, da: push_da_i, db: push_db_i};

  rxs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxs_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .push_i     (push_i),
    .rel_i      (release_i),
    .frame_i    (frame_in),
    .frame_o    (frame_out),
    .nonempty_o (full_o),
    .avail_d_o  (avail_d),
    .rel_eff_o  (rel_eff),
    .drop_o     (drop)
  );

  rxs_irq #(.HOLD_CYC(HOLD_CYC)) u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rel_eff_i (rel_eff),
    .avail_d_i (avail_d),
    .irq_o     (rx_irq_o)
  );

  rxs_ovr u_ovr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .drop_i    (drop),
    .clr_i     (clr_ovr_i),
    .ovr_o     (ovr_o),
    .ovr_irq_o (ovr_irq_o)
  );

  assign rd_info_o = frame_out.info;
  assign rd_id_o   = frame_out.id;
  assign rd_da_o   = frame_out.da;
  assign rd_db_o   = frame_out.db;
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker (
  input logic clk,
  input logic rst_n,
  input logic release_i,
  input logic clr_ovr_i,
  input logic full_o,
  input logic ovr_o,
  input logic rx_irq_o,
  input logic ovr_irq_o
);
  // R4: no interrupt without a stored frame
  p_irq_needs_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_o |-> full_o);

  // R5: interrupt gap, first cycle
  p_gap_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && full_o) |=> !rx_irq_o);

  // R5: interrupt gap, second cycle
  p_gap_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(release_i && full_o, 2) |-> !rx_irq_o);

  // R7: status holds without a clear
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && !clr_ovr_i) |=> ovr_o);

  // R7: pulse only with a rising status
  p_pulse_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_irq_o |-> $rose(ovr_o));

  // R7: pulse lasts one cycle
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_irq_o |=> !ovr_irq_o);

  // R8: a release makes room, so no overrun follows it
  p_no_ovr_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && full_o) |=> !$rose(ovr_o));
endmodule

bind rx_dual_store rxs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .release_i (release_i),
  .clr_ovr_i (clr_ovr_i),
  .full_o    (full_o),
  .ovr_o     (ovr_o),
  .rx_irq_o  (rx_irq_o),
  .ovr_irq_o (ovr_irq_o)
);

// File: tb/rx_dual_store_test.sv
module rx_dual_store_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0, release_i = 1'b0, clr_ovr_i = 1'b0;
  logic [31:0] push_info_i = '0, push_id_i = '0, push_da_i = '0, push_db_i = '0;
  logic [31:0] rd_info_o, rd_id_o, rd_da_o, rd_db_o;
  logic        full_o, ovr_o, rx_irq_o, ovr_irq_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_dual_store uut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i),
    .push_info_i(push_info_i), .push_id_i(push_id_i),
    .push_da_i(push_da_i), .push_db_i(push_db_i),
    .release_i(release_i), .clr_ovr_i(clr_ovr_i),
    .rd_info_o(rd_info_o), .rd_id_o(rd_id_o), .rd_da_o(rd_da_o), .rd_db_o(rd_db_o),
    .full_o(full_o), .ovr_o(ovr_o), .rx_irq_o(rx_irq_o), .ovr_irq_o(ovr_irq_o)
  );

  // bits: [26] push [25] release [24] clear [23:16] tag
  //       [15:12] expected full,irq,ovr,ovr_irq [11:4] expected visible tag [3:0] req
  localparam logic [26:0] VEC [NV] = '{
    {3'b100, 8'hA1, 4'b1100, 8'hA1, 4'd2},   // R2 push into empty
    {3'b100, 8'hA2, 4'b1100, 8'hA1, 4'd3},   // R3 oldest stays visible
    {3'b100, 8'hA3, 4'b1111, 8'hA1, 4'd6},   // R6 drop sets overrun
    {3'b100, 8'hA4, 4'b1110, 8'hA1, 4'd7},   // R7 no second pulse
    {3'b000, 8'h00, 4'b1110, 8'hA1, 4'd7},   // R7 sticky
    {3'b001, 8'h00, 4'b1100, 8'hA1, 4'd7},   // R7 cleared
    {3'b010, 8'h00, 4'b1000, 8'hA2, 4'd3},   // R3 next frame at once
    {3'b000, 8'h00, 4'b1000, 8'hA2, 4'd5},   // R5 gap second cycle
    {3'b000, 8'h00, 4'b1100, 8'hA2, 4'd5},   // R5 interrupt back
    {3'b100, 8'hA5, 4'b1100, 8'hA2, 4'd3},
    {3'b110, 8'hA6, 4'b1000, 8'hA5, 4'd8},   // R8 release with push
    {3'b000, 8'h00, 4'b1000, 8'hA5, 4'd5},
    {3'b000, 8'h00, 4'b1100, 8'hA5, 4'd5},
    {3'b010, 8'h00, 4'b1000, 8'hA6, 4'd3},
    {3'b010, 8'h00, 4'b0000, 8'h00, 4'd4},   // R4 last frame freed
    {3'b010, 8'h00, 4'b0000, 8'h00, 4'd9},   // R9 release on empty
    {3'b100, 8'hA7, 4'b1100, 8'hA7, 4'd9},   // R9 no gap restarted
    {3'b100, 8'hA8, 4'b1100, 8'hA7, 4'd2},
    {3'b100, 8'hA9, 4'b1111, 8'hA7, 4'd6},
    {3'b101, 8'hAA, 4'b1110, 8'hA7, 4'd10},  // R10 drop with clear
    {3'b001, 8'h00, 4'b1100, 8'hA7, 4'd7},
    {3'b100, 8'hAB, 4'b1111, 8'hA7, 4'd7},   // R7 rearmed pulse
    {3'b010, 8'h00, 4'b1010, 8'hA8, 4'd6}    // R6 stored order kept
  };

  function automatic logic [31:0] f_info(logic [7:0] t); return {24'h0, t}; endfunction
  function automatic logic [31:0] f_id(logic [7:0] t);   return {8'h5A, t, 8'h3C, ~t}; endfunction
  function automatic logic [31:0] f_da(logic [7:0] t);   return {4{t}}; endfunction
  function automatic logic [31:0] f_db(logic [7:0] t);   return ~{4{t}}; endfunction

  task automatic check(string what, int req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic p, logic r, logic c, logic [7:0] t);
    @(negedge clk);
    push_i = p; release_i = r; clr_ovr_i = c;
    push_info_i = f_info(t); push_id_i = f_id(t);
    push_da_i = f_da(t); push_db_i = f_db(t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1 state during reset
    repeat (2) @(negedge clk);
    check("full in reset", 1, 32'(full_o), 0);
    check("ovr in reset", 1, 32'(ovr_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("full after reset", 1, 32'(full_o), 0);
    check("irq after reset", 1, 32'(rx_irq_o), 0);
    check("ovr irq after reset", 1, 32'(ovr_irq_o), 0);

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      drive(v[26], v[25], v[24], v[23:16]);
      @(posedge clk);
      #1;
      check("full", int'(v[3:0]), 32'(full_o), 32'(v[15]));
      check("rx irq", int'(v[3:0]), 32'(rx_irq_o), 32'(v[14]));
      check("ovr", int'(v[3:0]), 32'(ovr_o), 32'(v[13]));
      check("ovr irq", int'(v[3:0]), 32'(ovr_irq_o), 32'(v[12]));
      if (v[15]) begin
        check("rd info", int'(v[3:0]), rd_info_o, f_info(v[11:4]));
        check("rd id", int'(v[3:0]), rd_id_o, f_id(v[11:4]));
        check("rd da", int'(v[3:0]), rd_da_o, f_da(v[11:4]));
        check("rd db", int'(v[3:0]), rd_db_o, f_db(v[11:4]));
      end
    end

    // R1 reset in the middle of operation empties the store
    drive(1'b1, 1'b0, 1'b0, 8'hB0);
    @(negedge clk);
    push_i = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    check("full at mid reset", 1, 32'(full_o), 0);
    check("ovr at mid reset", 1, 32'(ovr_o), 0);
    check("irq at mid reset", 1, 32'(rx_irq_o), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 8'hB1);
    @(posedge clk);
    #1;
    check("push after reset full", 1, 32'(full_o), 1);
    check("push after reset shows new", 1, rd_info_o, f_info(8'hB1));
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    @(posedge clk);
    #1;
    check("single frame after reset", 4, 32'(full_o), 0);
    drive(1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule